// File: doc/BRIEF.md
# Nibble-Folded 16-bit Checksum Engine

This block walks a byte-addressed memory region and reduces it to a 16-bit checksum. The checksum starts at 0xFFFF. Each step XORs the previous value with a 16-bit word and derives two nibbles from the low byte of the result. The new value is the old value shifted right by eight bits, XORed with shifted copies of those two nibbles. A caller supplies a base address and a byte count and pulses a start input. The engine then raises busy, fetches bytes through a synchronous read port, pulses done once, and holds the result until the next accepted start.

Words are built big-endian from two adjacent bytes. The window advances by one byte per step, so neighbouring words share a byte. The byte count is rounded down to an even number E, and E steps are taken. If the original count was odd, one more step folds in the byte at base+E as the high half of a word whose low half is zero. Each word costs two fresh reads, and no byte is reused from the previous window.

Control is a seven-state machine:
- ST_IDLE waits for start.
- ST_FETCH_HI issues the read of the high byte.
- ST_FETCH_LO issues the read of the low byte and captures the high byte.
- ST_FOLD captures the low byte and applies one step.
- ST_TAIL_FETCH reads the trailing byte.
- ST_TAIL_FOLD applies the trailing step.
- ST_FINISH raises done.

The transitions are:
- ST_IDLE goes to ST_FETCH_HI on start with a count of two or more, to ST_TAIL_FETCH on start with a count of one, and to ST_FINISH on start with a count of zero.
- ST_FETCH_HI goes to ST_FETCH_LO, and ST_FETCH_LO goes to ST_FOLD.
- ST_FOLD returns to ST_FETCH_HI while words remain. After the last word it goes to ST_TAIL_FETCH when the count is odd and to ST_FINISH when it is even.
- ST_TAIL_FETCH goes to ST_TAIL_FOLD, and ST_TAIL_FOLD goes to ST_FINISH.
- ST_FINISH always returns to ST_IDLE.

Top module: `nibfold_crc`

## Requirements
- R1: After reset, busy_o and done_o are 0, rd_en_o is 0, and crc_o is 0xFFFF.
- R2: One step maps prev and word v as follows. Let d = prev^v, a = d[3:0] and b = d[7:4]^a. The new value is (prev>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits. A count of 1 gives exactly one step on {byte(base), 8'h00}.
- R3: For an even count E, the result equals E steps from 0xFFFF. Step i uses the word {byte(base+i), byte(base+i+1)}, with the byte at the lower address in bits 15:8.
- R4: For an odd count N, after the N-1 overlapping steps one more step uses {byte(base+N-1), 8'h00}.
- R5: A count of 0 issues no read, and done_o rises in the cycle after start is taken, with crc_o equal to 0xFFFF.
- R6: Reads follow a fixed order. Each word reads base+i and then base+i+1 on consecutive cycles, and the tail reads base+E. Addresses wrap modulo 2^ADDR_W. rd_data_i is taken one cycle after rd_en_o.
- R7: done_o is high for exactly one cycle, busy_o is high from the cycle after acceptance through the done cycle, and the latency from the start edge to done is 3*E + 2*(N odd) + 1 cycles.
- R8: After done, crc_o holds its value until the next accepted start.
- R9: start_i while busy_o is 1 is ignored. The address sequence, result and latency of the running job are unchanged.
- R10: Every accepted start reloads the checksum to 0xFFFF, so repeating a job gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a job; taken only while idle |
| base_i | input | ADDR_W | First byte address of the region |
| len_i | input | CNT_W | Byte count of the region |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 16 | Running and final checksum |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | ADDR_W | Memory read byte address |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_en_o |

## Verification
The hardest situation to reach is a second start arriving in the middle of a word, between the high-byte and low-byte reads. A wrongly accepted start there would corrupt both the address stream and the captured high byte. The bench pulses start with a different base and count a few cycles into a long job. Its per-clock address comparison then exposes any deviation. The other corner cases are an odd count whose tail follows the overlapping windows, and a region that wraps past the top of the address space. Both are driven directly, with memory contents computed from the address so that every byte differs.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_FOLD,
        ST_TAIL_FETCH,
        ST_TAIL_FOLD,
        ST_FINISH
    } nfc_state_e;

    localparam logic [15:0] NFC_SEED = 16'hFFFF;

    // One nibble-folded update step.
    function automatic logic [15:0] nfc_step(input logic [15:0] prev,
                                             input logic [15:0] v);
        logic [15:0] pd;
        logic [3:0]  p1;
        logic [3:0]  p2;
        logic [15:0] r;
        pd = prev ^ v;
        p1 = pd[3:0];
        p2 = pd[7:4] ^ p1;
        r  = {8'h00, prev[15:8]};
        r  = r ^ {9'd0, p1, 3'd0};
        r  = r ^ {4'd0, p1, 8'd0};
        r  = r ^ {12'd0, p2};
        r  = r ^ {5'd0, p2, 7'd0};
        r  = r ^ {p2, 12'd0};
        return r;
    endfunction

endpackage

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       len_zero_i,
    input  logic       len_one_i,
    input  logic       last_word_i,
    input  logic       odd_i,
    output nfc_state_e state_o,
    output logic       accept_o,
    output logic       rd_en_o,
    output logic       cap_hi_o,
    output logic       step_o,
    output logic       tail_o,
    output logic       adv_o,
    output logic       busy_o,
    output logic       done_o
);

    nfc_state_e state_q;
    nfc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_zero_i) begin
                        state_d = ST_FINISH;
                    end else if (len_one_i) begin
                        state_d = ST_TAIL_FETCH;
                    end else begin
                        state_d = ST_FETCH_HI;
                    end
                end
            end
            ST_FETCH_HI:   state_d = ST_FETCH_LO;
            ST_FETCH_LO:   state_d = ST_FOLD;
            ST_FOLD: begin
                if (!last_word_i) begin
                    state_d = ST_FETCH_HI;
                end else if (odd_i) begin
                    state_d = ST_TAIL_FETCH;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_TAIL_FETCH: state_d = ST_TAIL_FOLD;
            ST_TAIL_FOLD:  state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = 1'b0;
        rd_en_o  = 1'b0;
        cap_hi_o = 1'b0;
        step_o   = 1'b0;
        tail_o   = 1'b0;
        adv_o    = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_FETCH_HI: rd_en_o = 1'b1;
            ST_FETCH_LO: begin
                rd_en_o  = 1'b1;
                cap_hi_o = 1'b1;
            end
            ST_FOLD: begin
                step_o = 1'b1;
                adv_o  = 1'b1;
            end
            ST_TAIL_FETCH: rd_en_o = 1'b1;
            ST_TAIL_FOLD: begin
                step_o = 1'b1;
                tail_o = 1'b1;
            end
            ST_FINISH: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a high-byte fetch is always followed by the matching low-byte fetch
    p_fetch_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_HI) |=> (rd_en_o && cap_hi_o));

endmodule

// File: rtl/nfc_addr.sv
module nfc_addr
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nfc_state_e        state_i,
    input  logic              accept_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              last_word_o,
    output logic              odd_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  even_q;
    logic [CNT_W-1:0]  idx_q;
    logic              odd_q;
    logic [ADDR_W-1:0] word_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            even_q <= '0;
            idx_q  <= '0;
            odd_q  <= 1'b0;
        end else if (accept_i) begin
            base_q <= base_i;
            even_q <= {len_i[CNT_W-1:1], 1'b0};
            odd_q  <= len_i[0];
            idx_q  <= '0;
        end else if (adv_i) begin
            idx_q  <= idx_q + CNT_ONE;
        end
    end

    assign word_addr   = base_q + ADDR_W'(idx_q);
    assign last_word_o = ((idx_q + CNT_ONE) == even_q);
    assign odd_o       = odd_q;

    always_comb begin
        unique case (state_i)
            ST_FETCH_LO:   rd_addr_o = word_addr + ADDR_W'(1);
            ST_TAIL_FETCH: rd_addr_o = base_q + ADDR_W'(even_q);
            default:       rd_addr_o = word_addr;
        endcase
    end

    // R6: the low-byte address is one above the high-byte address
    p_pair_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_FETCH_LO) |-> (rd_addr_o == $past(rd_addr_o) + ADDR_W'(1)));

    // R9: job parameters cannot change while a job runs
    p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE) |=> $stable(base_q));

endmodule

// File: rtl/nfc_fold.sv
module nfc_fold
    import nfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic        cap_hi_i,
    input  logic        step_i,
    input  logic        tail_i,
    input  logic        busy_i,
    input  logic [7:0]  rd_data_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;
    logic [7:0]  hi_q;
    logic [15:0] word;

    assign word = tail_i ? {rd_data_i, 8'h00} : {hi_q, rd_data_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= NFC_SEED;
            hi_q  <= 8'h00;
        end else begin
            if (cap_hi_i) begin
                hi_q <= rd_data_i;
            end
            if (load_i) begin
                crc_q <= NFC_SEED;
            end else if (step_i) begin
                crc_q <= nfc_step(crc_q, word);
            end
        end
    end

    assign crc_o = crc_q;

    // R10: an accepted start reseeds the checksum
    p_crc_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (crc_q == NFC_SEED));

    // R8: while idle and not restarting, the result holds
    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !load_i) |=> $stable(crc_q));

endmodule

// File: rtl/nibfold_crc.sv
module nibfold_crc
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       crc_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    nfc_state_e state;
    logic accept;
    logic cap_hi;
    logic step;
    logic tail;
    logic adv;
    logic last_word;
    logic odd;
    logic len_zero;
    logic len_one;

    assign len_zero = (len_i == '0);
    assign len_one  = (len_i == CNT_W'(1));

    nfc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_zero_i  (len_zero),
        .len_one_i   (len_one),
        .last_word_i (last_word),
        .odd_i       (odd),
        .state_o     (state),
        .accept_o    (accept),
        .rd_en_o     (rd_en_o),
        .cap_hi_o    (cap_hi),
        .step_o      (step),
        .tail_o      (tail),
        .adv_o       (adv),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    nfc_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .accept_i    (accept),
        .adv_i       (adv),
        .base_i      (base_i),
        .len_i       (len_i),
        .rd_addr_o   (rd_addr_o),
        .last_word_o (last_word),
        .odd_o       (odd)
    );

    nfc_fold u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .cap_hi_i  (cap_hi),
        .step_i    (step),
        .tail_i    (tail),
        .busy_i    (busy_o),
        .rd_data_i (rd_data_i),
        .crc_o     (crc_o)
    );

    // R5: an empty job finishes straight after acceptance without reading
    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_zero) |=> (done_o && !rd_en_o));

endmodule

// File: tb/nibfold_crc_tb.sv
module nibfold_crc_tb;

    logic        clk;
    logic        rst_n;
    logic        start_i;
    logic [15:0] base_i;
    logic [15:0] len_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] crc_o;
    logic        rd_en_o;
    logic [15:0] rd_addr_o;
    logic [7:0]  rd_data_i;

    int n_tests;
    int n_fail;
    int cyc;
    logic [7:0] seed;
    logic [15:0] exp_addr_q[$];

    nibfold_crc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .base_i    (base_i),
        .len_i     (len_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .crc_o     (crc_o),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A ^ seed;
    endfunction

    // memory model: registered read
    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= mem_byte(rd_addr_o);
    end

    function automatic int ref_step(input int prev, input int v);
        int d, a, b;
        d = (prev ^ v) & 'hFFFF;
        a = d & 15;
        b = ((d >> 4) & 15) ^ a;
        return ((prev >> 8) ^ (a * 8) ^ (a * 256) ^ b ^ (b * 128) ^ (b * 4096)) & 'hFFFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock read address comparison (R6)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && rd_en_o) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R6 unexpected read", int'(rd_addr_o), 0);
            end else begin
                logic [15:0] e;
                e = exp_addr_q.pop_front();
                check(rd_addr_o == e, "R6 read address", int'(rd_addr_o), int'(e));
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_op(input logic [15:0] base, input int len, input int poke,
                          input string req);
        int exp_crc, ev, odd, lat, cycles;
        logic [15:0] a;
        exp_crc = 'hFFFF;
        ev = len & ~1;
        odd = len & 1;
        for (int i = 0; i < ev; i++) begin
            a = base + 16'(i);
            exp_crc = ref_step(exp_crc, (int'(mem_byte(a)) << 8) | int'(mem_byte(a + 16'd1)));
            exp_addr_q.push_back(a);
            exp_addr_q.push_back(a + 16'd1);
        end
        if (odd != 0) begin
            a = base + 16'(ev);
            exp_crc = ref_step(exp_crc, int'(mem_byte(a)) << 8);
            exp_addr_q.push_back(a);
        end
        lat = 3 * ev + 2 * odd + 1;
        base_i = base;
        len_i = 16'(len);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cycles = 1;
        while (!done_o && cycles < 1000) begin
            check(busy_o == 1'b1, "R7 busy during job", int'(busy_o), 1);
            if (cycles == poke) begin
                base_i = base + 16'h0333;
                len_i = 16'd5;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cycles++;
        end
        start_i = 1'b0;
        check(crc_o == 16'(exp_crc), req, int'(crc_o), exp_crc);
        check(cycles == lat, "R7 latency", cycles, lat);
        check(exp_addr_q.size() == 0, "R6 all reads issued", exp_addr_q.size(), 0);
        exp_addr_q.delete();
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done one cycle", int'(done_o), 0);
        check(busy_o == 1'b0, "R7 idle after done", int'(busy_o), 0);
    endtask

    initial begin
        logic [15:0] held;
        n_tests = 0;
        n_fail = 0;
        cyc = 0;
        seed = 8'h00;
        rst_n = 1'b0;
        start_i = 1'b0;
        base_i = '0;
        len_i = '0;
        rd_data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
        check(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
        check(rd_en_o == 1'b0, "R1 rd_en reset", int'(rd_en_o), 0);
        check(crc_o == 16'hFFFF, "R1 crc reset", int'(crc_o), 'hFFFF);

        run_op(16'h0010, 1, -1, "R2 single step");
        run_op(16'h0020, 2, -1, "R3 two words");
        run_op(16'h0100, 8, -1, "R3 eight bytes");
        seed = 8'hC3;
        run_op(16'h4A00, 16, -1, "R3 sixteen bytes");
        run_op(16'h0200, 7, -1, "R4 odd seven");
        run_op(16'h0300, 3, -1, "R4 odd three");
        run_op(16'h0400, 0, -1, "R5 zero count");
        run_op(16'hFFFC, 6, -1, "R6 wrapping region");
        run_op(16'hFFFE, 3, -1, "R6 wrapping tail");

        // R8: result held while inputs move and start stays low
        held = crc_o;
        for (int k = 0; k < 6; k++) begin
            base_i = 16'(k * 77);
            len_i = 16'(k + 3);
            @(posedge clk);
            @(negedge clk);
            check(crc_o == held, "R8 result held", int'(crc_o), int'(held));
            check(rd_en_o == 1'b0, "R8 no reads idle", int'(rd_en_o), 0);
        end

        // R9: start pulses while busy, including mid-word
        run_op(16'h0500, 10, 3, "R9 start ignored mid job");
        run_op(16'h0600, 5, 2, "R9 start ignored odd job");

        // R10: identical back-to-back jobs give identical results
        seed = 8'h17;
        run_op(16'h0700, 9, -1, "R10 first run");
        run_op(16'h0700, 9, -1, "R10 repeat run");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule